// File: doc/BRIEF.md
# Retention-Binned Distributed Refresh Controller

This block paces refresh work for a single DRAM bank with a small, parameterised number of rows. A free-running interval counter produces a regular tick. On each tick, one row pointer position is considered, so the restore work is spread evenly over the base period instead of arriving as one long burst. Each row carries a two-bit retention class in a small table. The class decides on which passes of the pointer the row is actually restored: every pass, every second pass, or every fourth pass.

When a row is due, the controller raises a refresh request together with the row index. It holds them until the command side acknowledges. If the next tick arrives while a request is still outstanding, that tick is recorded as overdue and the outstanding row is kept. The activate and precharge sequencing, and working out each row's retention, belong to neighbouring logic.

The table is written through a simple write port. This port works at any time, including while reset is held. Reset does not clear the table, so software can load the classes before releasing the scheduler.

Top module: `refresh_bin_ctrl`

## Requirements
- R1: While and after reset, `ref_req` is 0, `ref_row` is 0 and `ref_overdue` is 0. The first tick falls on the TICK_CYCLES-th rising edge after reset is released, so the first request is visible right after that edge.
- R2: Ticks recur every TICK_CYCLES cycles. A request can only begin on a tick. Rows are visited in ascending order and wrap from NUM_ROWS-1 to 0, and each wrap advances a 2-bit pass count that starts at 0.
- R3: Class code 0 makes a row due on every pass. Code 1 makes it due when pass bit 0 is 0. Codes 2 and 3 make it due only when both pass bits are 0.
- R4: A row that is not due on a tick produces no request, and the pointer still moves on to the next row.
- R5: While `ref_req` is high and `ref_ack` is low, the request stays high and `ref_row` does not change.
- R6: A tick that finds a request high with `ref_ack` low adds one to `ref_overdue` and leaves the pointer where it is. No new row is considered on that tick.
- R7: `ref_overdue` saturates at its all-ones value. Acknowledging a request does not clear it.
- R8: A write (`cfg_we` high) stores `cfg_bin` as the class of row `cfg_row` on the next edge. The table accepts writes during reset and is not cleared by reset.
- R9: `ref_ack` sampled high while `ref_req` is high drops `ref_req` after that edge, unless that same edge is a tick that starts a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the scheduler |
| cfg_we | input | 1 | Class table write enable |
| cfg_row | input | ROW_W | Row whose class is written |
| cfg_bin | input | 2 | Class code to store |
| ref_req | output | 1 | Refresh request, held until acknowledged |
| ref_row | output | ROW_W | Row to restore |
| ref_ack | input | 1 | Command side accepts the request |
| ref_overdue | output | OVD_W | Saturating count of ticks that found a request still waiting |

## Verification
The bench loads a mix of all four class codes while reset is held. It then follows four full passes, in which the skipped rows must leave gaps in the request order. A design that tested the wrong pass bit would, for example, restore class-1 rows on odd passes. A design that stalled on skipped rows would shift every later index.

The bench then stops acknowledging. If a design dropped or replaced the held row, `ref_row` would change. If it advanced the pointer on overdue ticks, the next request after the late acknowledge would be a row other than 1. If the overdue counter wrapped, the bench would read a small value instead of 15 after seventeen missed ticks. The exact cycle of the first request is checked as well, to catch an off-by-one in the interval counter.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    localparam int PASS_W = 2;

    typedef enum logic [1:0] {
        BIN_FAST     = 2'd0,
        BIN_MID      = 2'd1,
        BIN_SLOW     = 2'd2,
        BIN_SLOW_ALT = 2'd3
    } bin_e;

    // A row is due when the low bits of the pass count selected by its class are zero.
    function automatic logic row_due(input bin_e b, input logic [PASS_W-1:0] pass);
        logic due;
        case (b)
            BIN_FAST: due = 1'b1;
            BIN_MID:  due = (pass[0] == 1'b0);
            default:  due = (pass == '0);
        endcase
        return due;
    endfunction

endpackage

// File: rtl/rbc_tick_gen.sv
module rbc_tick_gen #(
    parameter int TICK_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rbc_bin_table.sv
module rbc_bin_table #(
    parameter int NUM_ROWS = 8,
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [1:0]       wr_bin,
    input  logic [ROW_W-1:0] rd_row,
    output rbc_pkg::bin_e    rd_bin
);
    logic [1:0] cls_q [NUM_ROWS];

    // Configuration storage: deliberately outside the scheduler reset.
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && (wr_row == ROW_W'(r))) cls_q[r] <= wr_bin;
        end
    end

    always_comb begin
        rd_bin = rbc_pkg::BIN_FAST;
        for (int r = 0; r < NUM_ROWS; r++) begin
            if (rd_row == ROW_W'(r)) rd_bin = rbc_pkg::bin_e'(cls_q[r]);
        end
    end
endmodule

// File: rtl/rbc_row_sched.sv
module rbc_row_sched #(
    parameter int NUM_ROWS = 8,
    parameter int OVD_W    = 4,
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  rbc_pkg::bin_e        cur_bin,
    input  logic                 ack,
    output logic [ROW_W-1:0]     ptr,
    output logic                 req,
    output logic [ROW_W-1:0]     row,
    output logic [OVD_W-1:0]     overdue
);
    import rbc_pkg::*;

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);
    localparam logic [OVD_W-1:0] OVD_MAX  = {OVD_W{1'b1}};

    logic [ROW_W-1:0]  ptr_q, row_q;
    logic [PASS_W-1:0] pass_q;
    logic              req_q;
    logic [OVD_W-1:0]  ovd_q;
    logic              still_waiting;
    logic              due;

    assign still_waiting = req_q && !ack;
    assign due           = row_due(cur_bin, pass_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            pass_q <= '0;
            req_q  <= 1'b0;
            row_q  <= '0;
            ovd_q  <= '0;
        end else begin
            if (req_q && ack) req_q <= 1'b0;
            if (tick) begin
                if (still_waiting) begin
                    if (ovd_q != OVD_MAX) ovd_q <= ovd_q + 1'b1;
                end else begin
                    if (due) begin
                        req_q <= 1'b1;
                        row_q <= ptr_q;
                    end
                    if (ptr_q == LAST_ROW) begin
                        ptr_q  <= '0;
                        pass_q <= pass_q + 1'b1;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
            end
        end
    end

    assign ptr     = ptr_q;
    assign req     = req_q;
    assign row     = row_q;
    assign overdue = ovd_q;
endmodule

// File: rtl/refresh_bin_ctrl.sv
module refresh_bin_ctrl #(
    parameter int NUM_ROWS    = 8,
    parameter int TICK_CYCLES = 8,
    parameter int OVD_W       = 4,
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [ROW_W-1:0] cfg_row,
    input  logic [1:0]       cfg_bin,
    output logic             ref_req,
    output logic [ROW_W-1:0] ref_row,
    input  logic             ref_ack,
    output logic [OVD_W-1:0] ref_overdue
);
    logic             tick_w;
    logic [ROW_W-1:0] ptr_w;
    rbc_pkg::bin_e    bin_w;

    rbc_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_w)
    );

    rbc_bin_table #(.NUM_ROWS(NUM_ROWS)) u_table (
        .clk    (clk),
        .we     (cfg_we),
        .wr_row (cfg_row),
        .wr_bin (cfg_bin),
        .rd_row (ptr_w),
        .rd_bin (bin_w)
    );

    rbc_row_sched #(.NUM_ROWS(NUM_ROWS), .OVD_W(OVD_W)) u_sched (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_w),
        .cur_bin (bin_w),
        .ack     (ref_ack),
        .ptr     (ptr_w),
        .req     (ref_req),
        .row     (ref_row),
        .overdue (ref_overdue)
    );
endmodule

// File: rtl/refresh_bin_ctrl_chk.sv
module refresh_bin_ctrl_chk #(
    parameter int ROW_W = 3,
    parameter int OVD_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             ref_req,
    input logic [ROW_W-1:0] ref_row,
    input logic             ref_ack,
    input logic [OVD_W-1:0] ref_overdue
);
    localparam logic [OVD_W-1:0] OVD_MAX = {OVD_W{1'b1}};

    // R2: a request can only start on a tick
    p_start_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ref_req) |=> !ref_req);

    // R5: unacknowledged request holds with a stable row
    p_hold_row_r5: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_ack) |=> (ref_req && $stable(ref_row)));

    // R6: a tick over a waiting request bumps the overdue count
    p_overdue_bump_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && ref_req && !ref_ack && ref_overdue != OVD_MAX)
        |=> (ref_overdue == $past(ref_overdue) + 1'b1));

    // R7: saturated count stays saturated
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (ref_overdue == OVD_MAX) |=> (ref_overdue == OVD_MAX));

    // R9: acknowledge outside a tick clears the request
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_ack && !tick) |=> !ref_req);

    // R1: reset clears the outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!ref_req && ref_overdue == '0));
endmodule

bind refresh_bin_ctrl refresh_bin_ctrl_chk #(.ROW_W(ROW_W), .OVD_W(OVD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick_w),
    .ref_req     (ref_req),
    .ref_row     (ref_row),
    .ref_ack     (ref_ack),
    .ref_overdue (ref_overdue)
);

// File: tb/refresh_bin_ctrl_bench.sv
module refresh_bin_ctrl_bench;
    localparam int NUM_ROWS = 8;
    localparam int TICKS    = 8;
    localparam int OVD_W    = 4;
    localparam int ROW_W    = 3;

    // Per row: class code, and pass mask (bit p set => a request is expected on pass p).
    localparam logic [5:0] VEC [NUM_ROWS] = '{
        {2'd0, 4'b1111}, {2'd1, 4'b0101}, {2'd2, 4'b0001}, {2'd3, 4'b0001},
        {2'd2, 4'b0001}, {2'd0, 4'b1111}, {2'd1, 4'b0101}, {2'd2, 4'b0001}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [ROW_W-1:0] cfg_row = '0;
    logic [1:0]       cfg_bin = '0;
    logic             ref_req;
    logic [ROW_W-1:0] ref_row;
    logic             ref_ack = 1'b0;
    logic [OVD_W-1:0] ref_overdue;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    refresh_bin_ctrl #(.NUM_ROWS(NUM_ROWS), .TICK_CYCLES(TICKS), .OVD_W(OVD_W)) u_refresh_bin_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_bin(cfg_bin),
        .ref_req(ref_req), .ref_row(ref_row), .ref_ack(ref_ack), .ref_overdue(ref_overdue)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_req(output bit found);
        found = 1'b0;
        for (int i = 0; i < 4 * TICKS * NUM_ROWS; i++) begin
            if (ref_req) begin
                found = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic pulse_ack();
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit found;
        @(negedge clk);
        // R8: load the class table while reset is held
        for (int r = 0; r < NUM_ROWS; r++) begin
            cfg_we  = 1'b1;
            cfg_row = ROW_W'(r);
            cfg_bin = VEC[r][5:4];
            @(negedge clk);
        end
        cfg_we = 1'b0;
        check("R1 req in reset", int'(ref_req), 0);
        check("R1 row in reset", int'(ref_row), 0);
        check("R1 overdue in reset", int'(ref_overdue), 0);

        rst = 1'b0;
        repeat (TICKS - 1) @(posedge clk);
        @(negedge clk);
        check("R1 no request before first tick", int'(ref_req), 0);
        @(posedge clk);
        @(negedge clk);
        check("R1 first request on first tick", int'(ref_req), 1);

        // R2 R3 R4 R8: four passes, following the vector table
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < NUM_ROWS; r++) begin
                if (VEC[r][p]) begin
                    wait_req(found);
                    check($sformatf("R3 request present pass %0d row %0d", p, r), int'(found), 1);
                    if (!found) finish_run();
                    check($sformatf("R4 R2 R8 row index pass %0d", p), int'(ref_row), r);
                    pulse_ack();
                    check("R9 ack clears request", int'(ref_req), 0);
                end
            end
        end
        check("R6 no overdue while acked promptly", int'(ref_overdue), 0);

        // R5 R6 R7: stop acknowledging
        wait_req(found);
        check("R2 wrap to row 0", int'(ref_row), 0);
        repeat (3 * TICKS) @(posedge clk);
        @(negedge clk);
        check("R6 overdue after three missed ticks", int'(ref_overdue), 3);
        check("R5 request still held", int'(ref_req), 1);
        check("R5 held row unchanged", int'(ref_row), 0);
        repeat (14 * TICKS) @(posedge clk);
        @(negedge clk);
        check("R7 overdue saturates", int'(ref_overdue), 15);
        check("R5 row still held", int'(ref_row), 0);
        pulse_ack();
        check("R9 late ack clears", int'(ref_req), 0);
        check("R7 ack keeps overdue count", int'(ref_overdue), 15);
        wait_req(found);
        check("R6 pointer held during overdue", int'(ref_row), 1);
        pulse_ack();

        finish_run();
    end
endmodule